// File: doc/BRIEF.md
# Dual-Rail Four-Phase Handshake Stage

This block is the storage and flow-control shell around one stage of a self-timed dual-rail datapath. Every incoming bit travels as a pair of rails. An input bank of two-input Muller C-elements holds each rail, and each of those C-elements is gated by the stage's acknowledge input. A second bank of C-elements on the output side is gated by the acknowledge that comes back from the next stage. A completion detector watches the output bank. It reduces each rail pair to one "bit complete" flag and merges the flags through a tree of two-input C-elements. The result is the acknowledge output, and its complement is the acknowledge input of the stage.

A parameter selects one of two protocols. In the return-to-zero protocol the spacer is all rails low, and each bit is marked complete when either of its rails is high. In the return-to-one protocol the spacer is all rails high, and each bit is marked complete only when both of its rails are high. The C-elements are modelled as clocked state: y' = a·b + y·(a + b). The combinational function that would sit between the banks is not part of this block, so in this model the stage passes the word through unchanged.

Top module: `drHandshakeStage`

## Requirements
- R1: While the active-low reset is asserted, every rail of both banks sits at the spacer level of the selected protocol (0 for return-to-zero, 1 for return-to-one), `ackOut` is low and `ackIn` is high.
- R2: Return-to-zero data: bit value v is carried as rail1 = v and rail0 = !v. A word presented while `ackIn` is high, with `dnAck` following the complement of `ackOut`, appears unchanged on the output rails, and `ackOut` then rises.
- R3: Return-to-zero spacer: after `ackOut` has risen, presenting all-zero rails returns every output rail to 0, and `ackOut` then falls.
- R4: Return-to-one data: bit value v is carried as rail1 = !v and rail0 = v. A word presented while `ackIn` is low appears on the output rails, and `ackOut` then falls.
- R5: Return-to-one spacer: a stream opens with the all-one spacer. Once the output rails are all 1, `ackOut` rises, both straight after reset and after every data word.
- R6: `ackIn` is always the complement of `ackOut`.
- R7: `ackOut` rises only when every bit of the output bank is marked complete, and it falls only when no bit is marked complete. A word with even one bit still at spacer leaves `ackOut` unchanged.
- R8: While `dnAck` holds the value that blocks the next wavefront, the output rails keep their state and `ackOut` does not move, whatever the input bank holds.
- R9: An input-bank rail changes only to the value of the acknowledge input. A captured word is therefore held even if the input rails return to spacer before `ackIn` falls, and that held word is what later reaches the output.
- R10: With legal inputs, no output rail pair ever shows the illegal code (1,1 for return-to-zero, 0,0 for return-to-one).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the C-element state |
| rstN | input | 1 | Active-low reset; forces the spacer state |
| inRail1 | input | W | True-side rail of each incoming bit |
| inRail0 | input | W | False-side rail of each incoming bit |
| dnAck | input | 1 | Acknowledge input of the next stage; gates the output bank |
| outRail1 | output | W | True-side rail of the output bank |
| outRail0 | output | W | False-side rail of the output bank |
| ackIn | output | 1 | Acknowledge to the sender; complement of `ackOut` |
| ackOut | output | 1 | Completion of the output bank |

## Verification
The bench builds two instances side by side, one for each protocol, both six bits wide. Six is not a power of two, so the completion tree has to pad its leaves, and both spacer polarities and both data/spacer orders are covered in a single run. The return-to-zero instance also goes through a partially completed word, a stalled downstream acknowledge, and a word withdrawn early, which puts the hold behaviour of both C-element banks within reach.

// File: rtl/drStagePkg.sv
package drStagePkg;

  typedef enum logic {
    RTZ = 1'b0,
    RTO = 1'b1
  } protoE;

  // gate strobes handed from completion control to the register banks
  typedef struct packed {
    logic inGate;
    logic outGate;
  } gateS;

  function automatic logic spacerBit(protoE p);
    return (p == RTO);
  endfunction

endpackage

// File: rtl/drCelemBank.sv
module drCelemBank #(
  parameter int   W      = 8,
  parameter logic RSTVAL = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] railIn,
  input  logic         gate,
  output logic [W-1:0] railOut
);

  logic [W-1:0] gateVec;
  assign gateVec = {W{gate}};

  // C-element: follows when both inputs agree, otherwise holds
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) railOut <= {W{RSTVAL}};
    else       railOut <= (railIn & gateVec) | (railOut & (railIn | gateVec));
  end

endmodule

// File: rtl/drRegBanks.sv
module drRegBanks
  import drStagePkg::*;
#(
  parameter int    W     = 8,
  parameter protoE PROTO = RTZ
) (
  input  logic         clk,
  input  logic         rstN,
  input  gateS         gates,
  input  logic [W-1:0] inRail1,
  input  logic [W-1:0] inRail0,
  output logic [W-1:0] outRail1,
  output logic [W-1:0] outRail0
);

  localparam logic SPC = spacerBit(PROTO);

  logic [W-1:0] inR1, inR0;

  drCelemBank #(.W(W), .RSTVAL(SPC)) i_inBank1 (
    .clk(clk), .rstN(rstN), .railIn(inRail1), .gate(gates.inGate), .railOut(inR1));
  drCelemBank #(.W(W), .RSTVAL(SPC)) i_inBank0 (
    .clk(clk), .rstN(rstN), .railIn(inRail0), .gate(gates.inGate), .railOut(inR0));

  // function slot between the banks is outside this block: pass-through
  drCelemBank #(.W(W), .RSTVAL(SPC)) i_outBank1 (
    .clk(clk), .rstN(rstN), .railIn(inR1), .gate(gates.outGate), .railOut(outRail1));
  drCelemBank #(.W(W), .RSTVAL(SPC)) i_outBank0 (
    .clk(clk), .rstN(rstN), .railIn(inR0), .gate(gates.outGate), .railOut(outRail0));

  // R9
  in_bank_follows_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((inR1 ^ $past(inR1)) & (inR1 ^ {W{$past(gates.inGate)}})) == '0) &&
    (((inR0 ^ $past(inR0)) & (inR0 ^ {W{$past(gates.inGate)}})) == '0));

  generate
    if (PROTO == RTO) begin : g_legalRto
      // R10
      out_pair_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
        (outRail1 | outRail0) == {W{1'b1}});
    end else begin : g_legalRtz
      // R10
      out_pair_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
        (outRail1 & outRail0) == '0);
    end
  endgenerate

endmodule

// File: rtl/drCompletion.sv
module drCompletion
  import drStagePkg::*;
#(
  parameter int    W     = 8,
  parameter protoE PROTO = RTZ
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] outRail1,
  input  logic [W-1:0] outRail0,
  input  logic         dnAck,
  output gateS         gates,
  output logic         ackOut
);

  localparam int LVL = (W < 2) ? 1 : $clog2(W);
  localparam int NP  = 1 << LVL;

  logic [W-1:0]  bitDone;
  logic [NP-1:0] leaf;
  logic [NP-1:1] node, lhs, rhs;

  generate
    if (PROTO == RTO) begin : g_detRto
      assign bitDone = outRail1 & outRail0;
    end else begin : g_detRtz
      assign bitDone = outRail1 | outRail0;
    end

    for (genvar i = 0; i < NP; i++) begin : g_leaf
      if (i < W) begin : g_real
        assign leaf[i] = bitDone[i];
      end else begin : g_pad
        assign leaf[i] = bitDone[0];
      end
    end

    for (genvar n = 1; n < NP; n++) begin : g_node
      if (2 * n >= NP) begin : g_fromLeaf
        assign lhs[n] = leaf[2*n - NP];
        assign rhs[n] = leaf[2*n + 1 - NP];
      end else begin : g_fromNode
        assign lhs[n] = node[2*n];
        assign rhs[n] = node[2*n + 1];
      end
    end
  endgenerate

  // tree of two-input C-elements, all cleared by reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) node <= '0;
    else       node <= (lhs & rhs) | (node & (lhs | rhs));
  end

  assign ackOut        = node[1];
  assign gates.inGate  = ~node[1];
  assign gates.outGate = dnAck;

  // R7
  ack_rise_all_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOut) |-> (&bitDone));

  // R7
  ack_fall_none_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackOut) |-> (bitDone == '0));

endmodule

// File: rtl/drHandshakeStage.sv
module drHandshakeStage
  import drStagePkg::*;
#(
  parameter int    W     = 8,
  parameter protoE PROTO = RTZ
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] inRail1,
  input  logic [W-1:0] inRail0,
  input  logic         dnAck,
  output logic [W-1:0] outRail1,
  output logic [W-1:0] outRail0,
  output logic         ackIn,
  output logic         ackOut
);

  gateS gates;

  drCompletion #(.W(W), .PROTO(PROTO)) i_ctrl (
    .clk(clk), .rstN(rstN), .outRail1(outRail1), .outRail0(outRail0),
    .dnAck(dnAck), .gates(gates), .ackOut(ackOut));

  drRegBanks #(.W(W), .PROTO(PROTO)) i_data (
    .clk(clk), .rstN(rstN), .gates(gates), .inRail1(inRail1), .inRail0(inRail0),
    .outRail1(outRail1), .outRail0(outRail0));

  assign ackIn = gates.inGate;

endmodule

// File: tb/test_drHandshakeStage.sv
module test_drHandshakeStage;
  import drStagePkg::*;

  localparam int W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] r1 [2];
  logic [W-1:0] r0 [2];
  logic [W-1:0] o1 [2];
  logic [W-1:0] o0 [2];
  logic dn [2];
  logic ai [2];
  logic ao [2];
  logic stall [2];

  int total = 0;
  int fails = 0;
  int illegalSeen = 0;
  int cyc = 0;

  for (genvar k = 0; k < 2; k++) begin : g_dut
    // block value: RZ data needs dnAck high to pass, RO data needs it low
    assign dn[k] = stall[k] ? (k == 1) : ~ao[k];
    drHandshakeStage #(.W(W), .PROTO(protoE'(k))) i_drHandshakeStage (
      .clk(clk), .rstN(rstN), .inRail1(r1[k]), .inRail0(r0[k]), .dnAck(dn[k]),
      .outRail1(o1[k]), .outRail0(o0[k]), .ackIn(ai[k]), .ackOut(ao[k]));
  end

  function automatic logic [W-1:0] enc1(int k, logic [W-1:0] v);
    return (k == 0) ? v : ~v;
  endfunction
  function automatic logic [W-1:0] spc(int k);
    return (k == 0) ? '0 : '1;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic present(int k, logic [W-1:0] v);
    r1[k] = enc1(k, v);
    r0[k] = ~enc1(k, v);
  endtask
  task automatic presentSpacer(int k);
    r1[k] = spc(k);
    r0[k] = spc(k);
  endtask

  task automatic waitAck(int k, logic lvl, string tag);
    for (int n = 0; n < 60; n++) begin
      if (ao[k] == lvl) break;
      @(negedge clk);
    end
    check(ao[k] == lvl, tag, 32'(ao[k]), 32'(lvl));
  endtask

  task automatic checkWord(int k, logic [W-1:0] v, string tag);
    check(o1[k] == enc1(k, v) && o0[k] == ~enc1(k, v), tag,
          {o1[k], o0[k]}, {enc1(k, v), ~enc1(k, v)});
  endtask
  task automatic checkSpacer(int k, string tag);
    check(o1[k] == spc(k) && o0[k] == spc(k), tag, {o1[k], o0[k]}, {spc(k), spc(k)});
  endtask

  // one full four-phase transaction in the protocol's own order
  task automatic transfer(int k, logic [W-1:0] v);
    if (k == 0) begin
      present(0, v);
      waitAck(0, 1'b1, "R2");
      checkWord(0, v, "R2");
      check(ai[0] == ~ao[0], "R6", 32'(ai[0]), 32'(~ao[0]));
      presentSpacer(0);
      waitAck(0, 1'b0, "R3");
      checkSpacer(0, "R3");
      check(ai[0] == ~ao[0], "R6", 32'(ai[0]), 32'(~ao[0]));
    end else begin
      waitAck(1, 1'b1, "R5");
      checkSpacer(1, "R5");
      present(1, v);
      waitAck(1, 1'b0, "R4");
      checkWord(1, v, "R4");
      check(ai[1] == ~ao[1], "R6", 32'(ai[1]), 32'(~ao[1]));
      presentSpacer(1);
      waitAck(1, 1'b1, "R5");
      checkSpacer(1, "R5");
      check(ai[1] == ~ao[1], "R6", 32'(ai[1]), 32'(~ao[1]));
    end
  endtask

  // R10 monitor of illegal rail pairs on both instances
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if ((o1[0] & o0[0]) != '0) illegalSeen++;
      if ((~o1[1] & ~o0[1]) != '0) illegalSeen++;
    end
  end

  initial begin : watchdog
    wait (cyc > 150000);
    check(1'b0, "watchdog", 32'(cyc), 32'd150000);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] v;
    void'($urandom(32'd1234));
    for (int k = 0; k < 2; k++) begin
      stall[k] = 1'b0;
      presentSpacer(k);
    end
    repeat (3) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      checkSpacer(k, "R1");
      check(ao[k] == 1'b0 && ai[k] == 1'b1, "R1", {ao[k], ai[k]}, 2'b01);
    end
    rstN = 1'b1;
    @(negedge clk);

    // directed corners on both protocols
    for (int k = 0; k < 2; k++) begin
      transfer(k, '0);
      transfer(k, '1);
      transfer(k, 6'h2A);
    end

    // R7: one bit left at spacer keeps the stage incomplete (RZ instance)
    v = 6'h2D;
    present(0, v);
    r1[0][2] = 1'b0;
    r0[0][2] = 1'b0;
    repeat (30) @(negedge clk);
    check(ao[0] == 1'b0, "R7", 32'(ao[0]), 32'd0);
    present(0, v);
    waitAck(0, 1'b1, "R7");
    checkWord(0, v, "R7");
    presentSpacer(0);
    waitAck(0, 1'b0, "R3");

    // R8 stall, R9 early withdrawal held by the input bank
    v = 6'h35;
    stall[0] = 1'b1;
    present(0, v);
    repeat (3) @(negedge clk);
    presentSpacer(0);
    repeat (8) @(negedge clk);
    checkSpacer(0, "R8");
    check(ao[0] == 1'b0, "R8", 32'(ao[0]), 32'd0);
    stall[0] = 1'b0;
    waitAck(0, 1'b1, "R9");
    checkWord(0, v, "R9");
    waitAck(0, 1'b0, "R9");
    checkSpacer(0, "R9");

    // constrained random words on both protocols
    for (int t = 0; t < 20; t++) begin
      for (int k = 0; k < 2; k++) begin
        v = W'($urandom);
        transfer(k, v);
      end
    end

    check(illegalSeen == 0, "R10", 32'(illegalSeen), 32'd0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule